// File: doc/BRIEF.md
# Recirculating 64-Stage Serial Shift Register

This block is a serial-in, serial-out delay line of 64 full stages that are clocked on the rising edge. A two-way source selector sits in front of the first stage. With the mode input high, the bit taken in comes from a dedicated recirculation input. With the mode input low, the bit comes from the primary serial input. When the recirculation input is wired back to the serial output, the stored 64-bit word circulates without loss. The mode input can also simply switch between two independent data streams.

Two outputs exist for chaining several registers. A half stage samples the serial output on the falling edge, so it presents the same bit half a clock later; a downstream register with slowly ramping clocks can take its data from there. A buffered copy of the clock is also brought out as a plain logic output, so it can drive the next register in a chain. There is no reset. Contents are defined once 64 known bits have been shifted in, and they are kept for as long as the clock stays at either level.

Top module: `recirc_shreg64`

## Requirements
- R1: A bit taken in on a rising edge reaches `q_out` on the 64th rising edge counted from that one, and not before.
- R2: On every rising edge each stage takes the value of the stage before it, so `q_out` takes the value that stage 63 held just before the edge.
- R3: When `mode_sel` is 1 at a rising edge, the bit taken into stage 1 is `data_recirc`, and `data_pri` has no effect.
- R4: When `mode_sel` is 0 at a rising edge, the bit taken into stage 1 is `data_pri`, and `data_recirc` has no effect.
- R5: `q_half` takes the value of `q_out` on each falling edge. It holds that value through the following high-clock phase, so while the clock is high it still shows the pre-edge `q_out`.
- R6: While the clock stays high or stays low for any length of time, `q_out` and `q_half` keep their values and the stored word is unchanged, whatever the data and mode inputs do.
- R7: `clk_dly` has the same logic level as `clk_in` in every clock phase.
- R8: With `mode_sel` at 1 and `data_recirc` fed from `q_out`, the sequence on `q_out` repeats with a period of exactly 64 rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Shift clock; the stages advance on its rising edge |
| mode_sel | input | 1 | 1 selects `data_recirc`, 0 selects `data_pri` |
| data_pri | input | 1 | Primary serial data input |
| data_recirc | input | 1 | Recirculation serial data input |
| q_out | output | 1 | Output of stage 64 |
| q_half | output | 1 | Half-stage copy of `q_out`, updated on the falling edge |
| clk_dly | output | 1 | Buffered copy of `clk_in` for a downstream register |

## Verification
The source selection and the output shift take effect on the same rising edge. When the bench loops the output back in recirculation mode, the bit leaving stage 64 is the same bit that enters stage 1 on that edge. The bench drives `data_recirc` from the pre-edge `q_out` and checks that the word comes back intact 64 edges later. In the same cycle it checks that `q_half` still shows the bit that was just shifted out, and that the unselected input was changed to the opposite value with no effect.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
    parameter int unsigned SHREG_DEPTH = 64;
    parameter int unsigned CLK_BUF_PAIRS = 1;

    typedef enum logic {
        SRC_PRIMARY = 1'b0,
        SRC_RECIRC  = 1'b1
    } src_sel_e;
endpackage

// File: rtl/shreg_src_sel.sv
module shreg_src_sel
    import shreg_pkg::*;
(
    input  logic sel_i,
    input  logic pri_i,
    input  logic rec_i,
    output logic bit_o
);
    src_sel_e sel_e;

    always_comb begin
        sel_e = src_sel_e'(sel_i);
        unique case (sel_e)
            SRC_RECIRC:  bit_o = rec_i;
            SRC_PRIMARY: bit_o = pri_i;
            default:     bit_o = pri_i;
        endcase
    end
endmodule

// File: rtl/shreg_chain.sv
module shreg_chain #(
    parameter int unsigned DEPTH = 64
) (
    input  logic             clk_i,
    input  logic             din_i,
    output logic [DEPTH-1:0] stages_o
);
    localparam int unsigned LAST = DEPTH - 1;

    logic [DEPTH-1:0] stg;

    // stage 0 takes the selected input bit
    always_ff @(posedge clk_i) begin
        stg[0] <= din_i;
    end

    // remaining stages each take their predecessor
    for (genvar gi = 1; gi <= LAST; gi++) begin : g_stage
        always_ff @(posedge clk_i) begin
            stg[gi] <= stg[gi-1];
        end
    end

    assign stages_o = stg;
endmodule

// File: rtl/shreg_half_stage.sv
module shreg_half_stage (
    input  logic clk_i,
    input  logic d_i,
    output logic q_o
);
    always_ff @(negedge clk_i) begin
        q_o <= d_i;
    end
endmodule

// File: rtl/shreg_clk_buf.sv
module shreg_clk_buf #(
    parameter int unsigned PAIRS = 1
) (
    input  logic clk_i,
    output logic clk_o
);
    localparam int unsigned NODES = 2 * PAIRS;

    logic [NODES:0] node;

    assign node[0] = clk_i;

    for (genvar gi = 0; gi < NODES; gi++) begin : g_inv
        assign node[gi+1] = ~node[gi];
    end

    assign clk_o = node[NODES];
endmodule

// File: rtl/recirc_shreg64.sv
module recirc_shreg64
    import shreg_pkg::*;
#(
    parameter int unsigned DEPTH     = SHREG_DEPTH,
    parameter int unsigned BUF_PAIRS = CLK_BUF_PAIRS
) (
    input  logic clk_in,
    input  logic mode_sel,
    input  logic data_pri,
    input  logic data_recirc,
    output logic q_out,
    output logic q_half,
    output logic clk_dly
);
    localparam int unsigned LAST = DEPTH - 1;

    logic             head_bit;
    logic [DEPTH-1:0] stages;

    shreg_src_sel u_src (
        .sel_i (mode_sel),
        .pri_i (data_pri),
        .rec_i (data_recirc),
        .bit_o (head_bit)
    );

    shreg_chain #(.DEPTH(DEPTH)) u_chain (
        .clk_i    (clk_in),
        .din_i    (head_bit),
        .stages_o (stages)
    );

    assign q_out = stages[LAST];

    shreg_half_stage u_half (
        .clk_i (clk_in),
        .d_i   (q_out),
        .q_o   (q_half)
    );

    shreg_clk_buf #(.PAIRS(BUF_PAIRS)) u_cbuf (
        .clk_i (clk_in),
        .clk_o (clk_dly)
    );

    // Checker qualifiers: set once a rising and then a falling edge have been seen
    logic live_p = 1'b0;
    logic live_n = 1'b0;

    always_ff @(posedge clk_in) begin
        live_p <= 1'b1;
    end

    always_ff @(negedge clk_in) begin
        live_n <= live_p;
    end

    // R3
    mode_recirc_chk: assert property (@(posedge clk_in) disable iff (!live_p)
        mode_sel |=> stages[0] == $past(data_recirc));

    // R4
    mode_primary_chk: assert property (@(posedge clk_in) disable iff (!live_p)
        !mode_sel |=> stages[0] == $past(data_pri));

    // R2
    shift_out_chk: assert property (@(posedge clk_in) disable iff (!live_p)
        1'b1 |=> q_out == $past(stages[LAST-1]));

    // R5
    half_lag_chk: assert property (@(posedge clk_in) disable iff (!live_n)
        q_half == q_out);

    // R5
    half_capture_chk: assert property (@(negedge clk_in) disable iff (!live_n)
        1'b1 |=> q_half == $past(q_out));
endmodule

// File: tb/recirc_shreg64_bench.sv
`timescale 1ns/1ps
module recirc_shreg64_bench;
    localparam int unsigned N = 64;

    logic clk_in = 1'b0;
    logic mode_sel = 1'b0;
    logic data_pri = 1'b0;
    logic data_recirc = 1'b0;
    logic q_out, q_half, clk_dly;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [N-1:0] mdl = '0;
    int filled = 0;
    logic prev_q = 1'b0;

    recirc_shreg64 u_recirc_shreg64 (
        .clk_in      (clk_in),
        .mode_sel    (mode_sel),
        .data_pri    (data_pri),
        .data_recirc (data_recirc),
        .q_out       (q_out),
        .q_half      (q_half),
        .clk_dly     (clk_dly)
    );

    task automatic chk(input bit ok, input string req, input logic act, input logic exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // one full clock period of 5 ns; inputs set during the low phase
    task automatic step(input logic m, input logic p, input logic r);
        logic src;
        mode_sel = m;
        data_pri = p;
        data_recirc = r;
        #1.25;
        prev_q = mdl[N-1];
        src = m ? r : p;
        clk_in = 1'b1;
        mdl = {mdl[N-2:0], src};
        if (filled < N) filled++;
        #1.25;
        chk(clk_dly === 1'b1, "R7 high", clk_dly, 1'b1);
        if (filled >= N) begin
            chk(q_out === mdl[N-1], "R2 q after rise", q_out, mdl[N-1]);
            chk(q_half === prev_q, "R5 half in high phase", q_half, prev_q);
        end
        #1.25;
        clk_in = 1'b0;
        #1.25;
        chk(clk_dly === 1'b0, "R7 low", clk_dly, 1'b0);
        if (filled >= N)
            chk(q_half === q_out && q_out === mdl[N-1], "R5 half after fall", q_half, mdl[N-1]);
    endtask

    task automatic t_fill;
        for (int i = 0; i < N; i++) step(1'b0, 1'(i % 3 == 0), 1'b0);
        chk(q_out === mdl[N-1], "R2 filled", q_out, mdl[N-1]);
    endtask

    task automatic t_depth;
        for (int i = 0; i < N; i++) step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b0);
        for (int i = 1; i < N; i++) begin
            step(1'b0, 1'b0, 1'b1);
            if (i < N - 1) chk(q_out === 1'b0, "R1 early", q_out, 1'b0);
        end
        chk(q_out === 1'b1, "R1 marker at 64th edge", q_out, 1'b1);
    endtask

    task automatic t_primary;
        for (int i = 0; i < 2 * N; i++) begin
            logic b;
            b = 1'((i * 7 + i / 5) % 2);
            step(1'b0, b, ~b);
        end
        chk(q_out === mdl[N-1], "R4 primary stream", q_out, mdl[N-1]);
    endtask

    task automatic t_recirc_in;
        for (int i = 0; i < 2 * N; i++) begin
            logic b;
            b = 1'((i / 3) % 2);
            step(1'b1, ~b, b);
        end
        chk(q_out === mdl[N-1], "R3 recirc stream", q_out, mdl[N-1]);
    endtask

    task automatic t_loop;
        logic [N-1:0] snap;
        logic [N-1:0] seen;
        snap = mdl;
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < N; i++) begin
                seen[i] = q_out;
                step(1'b1, ~q_out, q_out);
            end
            chk(mdl === snap, "R8 word after 64 edges", mdl[N-1], snap[N-1]);
            chk(q_out === snap[N-1], "R8 q repeats", q_out, snap[N-1]);
        end
        for (int i = 0; i < N; i++)
            chk(seen[i] === snap[N-1-i], "R8 sequence order", seen[i], snap[N-1-i]);
    endtask

    task automatic t_static;
        logic hq, hh;
        #1.25;
        clk_in = 1'b1;
        mdl = {mdl[N-2:0], mode_sel ? data_recirc : data_pri};
        #1.25;
        hq = q_out;
        hh = q_half;
        chk(hq === mdl[N-1], "R6 entry", hq, mdl[N-1]);
        for (int i = 0; i < 40; i++) begin
            mode_sel = 1'(i % 2);
            data_pri = 1'(i % 3 == 0);
            data_recirc = 1'(i % 5 == 0);
            #5;
        end
        chk(q_out === hq, "R6 q held high", q_out, hq);
        chk(q_half === hh, "R6 half held high", q_half, hh);
        clk_in = 1'b0;
        #1.25;
        hq = q_out;
        hh = q_half;
        for (int i = 0; i < 40; i++) begin
            mode_sel = 1'(i % 2 == 0);
            data_pri = 1'(i % 4 == 0);
            data_recirc = 1'(i % 3 == 1);
            #5;
        end
        chk(q_out === hq, "R6 q held low", q_out, hq);
        chk(q_half === hh, "R6 half held low", q_half, hh);
        for (int i = 0; i < N; i++) step(1'b0, 1'b0, 1'b0);
        chk(q_out === mdl[N-1], "R6 word intact after hold", q_out, mdl[N-1]);
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #2.5;
        t_fill();
        t_depth();
        t_primary();
        t_recirc_in();
        t_loop();
        t_static();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule